// File: doc/BRIEF.md
# Serial-Addressed Bidirectional Port with Compare

This block is an SPI slave that owns an 8-bit general-purpose port. Internally it keeps three registers: the value driven onto output pins, a per-pin direction mask, and a reference value for a comparator. Each pin whose direction bit is 1 drives the stored output value. Each pin whose direction bit is 0 is an input, and the comparator watches only those pins.

A transaction runs while the active-low chip select is held low and is 16 SCK cycles long. The first byte is a control byte and the second is a data byte. The control byte carries a 3-bit device address, a direction-of-transfer bit, a 2-bit write format and a 2-bit compare selection. While the control byte is clocked in, the block sends back the compare flag on every bit. During a read, the data byte returns the pin state, and the byte the master sends at the same time becomes the new compare reference.

SPI inputs are sampled by the system clock. They must already be synchronous to it, and each SCK half period must last at least two system clocks. SCK idles low. MISO is given as a data/enable pair so that a pad or bus mux can tristate it.

Top module: `iox_spi_port`

## Requirements
- R1: After reset, port_out is 0x00, port_oe is 0x00 (all pins inputs), the compare reference is 0x00 and the compare selection is "equal".
- R2: spi_miso_oe is 0 whenever spi_cs_n is 1.
- R3: MOSI is captured on each falling SCK edge, most significant bit first. MISO changes only after rising SCK edges. A complete frame is 16 falling edges: the control byte, then the data byte.
- R4: Control byte layout is bits 7:5 address, bit 4 write (1) / read (0), bits 3:2 format, bits 1:0 compare selection. If bits 7:5 differ from dev_addr, no register changes, and spi_miso_oe drops to 0 once the eighth bit has been received.
- R5: Every MISO bit of the control byte equals the compare flag as it stood when spi_cs_n fell. That flag is computed from the reference and selection set by earlier transactions.
- R6: Read (bit 4 = 0): the data byte on MISO is the pin state taken when the control byte completes, MSB first. The received data byte is loaded into the compare reference.
- R7: Write format 00 loads the data byte into the output register. Format 01 loads it into the direction register, where 1 means output.
- R8: Write format 10 sets the output-register bits that are 1 in the data byte. Format 11 clears them.
- R9: Compare selection 00 flags pins == reference, 01 flags pins != reference, 10 flags pins > reference and 11 flags pins < reference (unsigned). Pins configured as outputs are forced to 0 on both sides before the comparison.
- R10: If spi_cs_n rises before the 16th falling edge, no register changes. No register changes while the block is deselected.
- R11: port_oe shows the direction register and port_out shows the output register. A completed frame takes effect within two system clocks of its 16th falling edge. A valid frame also stores its compare selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_addr | input | 3 | Strapped device address |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | MISO drive enable (0 = high impedance) |
| port_in | input | 8 | Sensed pin levels |
| port_out | output | 8 | Output register value for the pins |
| port_oe | output | 8 | Per-pin output enable (direction register) |

## Verification
Each SCK edge is seen by the block at the first system clock after it changes. A MISO bit is therefore valid one clock after the rising SCK edge, and the bench reads it four clocks later, just before it lowers SCK. Register writes land two clocks after the 16th falling edge. The bench reads port_out and port_oe only after a further half bit and the deselect, and it checks the miso enable after deselect has settled. The expected flag is taken from the bench model at the moment chip select falls. The expected read byte is the modelled pin state, which stays fixed through each frame.

// File: rtl/iox_pkg.sv
// Shared types for the serial port expander.
// Assumes an 8-bit control byte with fixed field positions.
package iox_pkg;
    localparam int CTRL_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        FMT_LOAD = 2'b00,
        FMT_DIR  = 2'b01,
        FMT_SET  = 2'b10,
        FMT_CLR  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        CMP_EQ = 2'b00,
        CMP_NE = 2'b01,
        CMP_GT = 2'b10,
        CMP_LT = 2'b11
    } cmp_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        fmt_e              fmt;
        cmp_e              mode;
    } ctrl_t;
endpackage

// File: rtl/iox_shift.sv
// Serial engine: detects SCK edges in the system clock domain, assembles the
// 16-bit frame, serialises the compare flag and the pin snapshot on MISO.
// Assumes cs_n/sck/mosi are synchronous to clk, SCK idles low, and each
// SCK half period spans at least two clk cycles.
module iox_shift
    import iox_pkg::*;
#(
    parameter int PORT_W  = 8,
    localparam int FRAME_W = CTRL_W + PORT_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sck,
    input  logic               mosi,
    input  logic               flag,
    input  logic [ADDR_W-1:0]  dev_addr,
    input  logic [PORT_W-1:0]  snap_in,
    output logic               miso,
    output logic               miso_oe,
    output logic               frame_done,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   bit_cnt
);
    logic              cs_q;
    logic              sck_q;
    logic              addr_ok;
    logic [PORT_W-1:0] tx;
    logic              miso_q;

    logic start, sel, rise, fall, in_frame, in_data, ctrl_last;
    assign sel       = !cs_n;
    assign start     = sel && cs_q;
    assign rise      = sel && !start && sck && !sck_q;
    assign fall      = sel && !start && !sck && sck_q;
    assign in_frame  = bit_cnt < CNT_W'(FRAME_W);
    assign in_data   = bit_cnt >= CNT_W'(CTRL_W);
    assign ctrl_last = fall && (bit_cnt == CNT_W'(CTRL_W - 1));

    // Remember previous chip-select and SCK levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sck;
        end
    end

    // Count received bits and shift MOSI in on falling SCK edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            frame   <= '0;
        end else if (!sel) begin
            bit_cnt <= '0;
        end else if (fall && in_frame) begin
            bit_cnt <= bit_cnt + 1'b1;
            frame   <= {frame[FRAME_W-2:0], mosi};
        end
    end

    // Pulse once when the last bit of a full frame arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_done <= 1'b0;
        else        frame_done <= fall && (bit_cnt == CNT_W'(FRAME_W - 1));
    end

    // Judge the address as the control byte completes.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel)
            addr_ok <= 1'b0;
        else if (ctrl_last)
            addr_ok <= (frame[CTRL_W-2 -: ADDR_W] == dev_addr);
    end

    // Snapshot the pins after the control byte, then shift them out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx <= '0;
        else if (ctrl_last)
            tx <= snap_in;
        else if (rise && in_data && in_frame)
            tx <= {tx[PORT_W-2:0], 1'b0};
    end

    // Drive the flag from select onward, then the snapshot bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            miso_q <= 1'b0;
        else if (start)
            miso_q <= flag;
        else if (rise && in_data && in_frame)
            miso_q <= tx[PORT_W-1];
    end

    assign miso    = miso_q;
    assign miso_oe = sel && (!in_data || addr_ok);
endmodule

// File: rtl/iox_cmp.sv
// Masked comparator: output pins are zeroed on both sides before the
// selected relation between the pins and the reference is evaluated.
// Assumes direction bit 1 marks an output pin.
module iox_cmp
    import iox_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic [PORT_W-1:0] pins,
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] ref_val,
    input  cmp_e              mode,
    output logic              flag
);
    logic [PORT_W-1:0] lhs;
    logic [PORT_W-1:0] rhs;

    for (genvar i = 0; i < PORT_W; i++) begin : g_mask
        assign lhs[i] = pins[i]    & ~dir[i];
        assign rhs[i] = ref_val[i] & ~dir[i];
    end

    // Select the relation named by the stored compare mode.
    always_comb begin
        unique case (mode)
            CMP_EQ: flag = (lhs == rhs);
            CMP_NE: flag = (lhs != rhs);
            CMP_GT: flag = (lhs >  rhs);
            CMP_LT: flag = (lhs <  rhs);
            default: flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/iox_regs.sv
// Register bank: commits a completed, address-matched frame to the output,
// direction and compare registers and stores its compare selection.
// Assumes frame is stable while done is high.
module iox_regs
    import iox_pkg::*;
#(
    parameter int PORT_W  = 8,
    localparam int FRAME_W = CTRL_W + PORT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done,
    input  logic [FRAME_W-1:0] frame,
    input  logic [ADDR_W-1:0]  dev_addr,
    output logic [PORT_W-1:0]  data_q,
    output logic [PORT_W-1:0]  dir_q,
    output logic [PORT_W-1:0]  ref_q,
    output cmp_e               mode_q
);
    ctrl_t             ctrl;
    logic [PORT_W-1:0] payload;
    assign ctrl    = ctrl_t'(frame[FRAME_W-1 -: CTRL_W]);
    assign payload = frame[PORT_W-1:0];

    // Apply the decoded operation once per accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            ref_q  <= '0;
            mode_q <= CMP_EQ;
        end else if (done && (ctrl.addr == dev_addr)) begin
            mode_q <= ctrl.mode;
            if (ctrl.wr) begin
                unique case (ctrl.fmt)
                    FMT_LOAD: data_q <= payload;
                    FMT_DIR:  dir_q  <= payload;
                    FMT_SET:  data_q <= data_q | payload;
                    FMT_CLR:  data_q <= data_q & ~payload;
                    default:  data_q <= data_q;
                endcase
            end else begin
                ref_q <= payload;
            end
        end
    end
endmodule

// File: rtl/iox_spi_port.sv
// Top level: SPI-addressed 8-bit bidirectional port with masked compare.
// Assumes SPI inputs synchronous to clk; MISO leaves as data plus enable.
module iox_spi_port
    import iox_pkg::*;
#(
    parameter int PORT_W = 8,
    localparam int FRAME_W = CTRL_W + PORT_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [PORT_W-1:0] port_in,
    output logic [PORT_W-1:0] port_out,
    output logic [PORT_W-1:0] port_oe
);
    logic               frame_done;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   bit_cnt;
    logic               cmp_flag;
    logic [PORT_W-1:0]  data_q, dir_q, ref_q;
    cmp_e               mode_q;

    iox_shift #(.PORT_W(PORT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck),
        .mosi(spi_mosi), .flag(cmp_flag), .dev_addr(dev_addr),
        .snap_in(port_in), .miso(spi_miso), .miso_oe(spi_miso_oe),
        .frame_done(frame_done), .frame(frame), .bit_cnt(bit_cnt)
    );

    iox_cmp #(.PORT_W(PORT_W)) u_cmp (
        .pins(port_in), .dir(dir_q), .ref_val(ref_q), .mode(mode_q),
        .flag(cmp_flag)
    );

    iox_regs #(.PORT_W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .done(frame_done), .frame(frame),
        .dev_addr(dev_addr), .data_q(data_q), .dir_q(dir_q),
        .ref_q(ref_q), .mode_q(mode_q)
    );

    assign port_out = data_q;
    assign port_oe  = dir_q;
endmodule

// File: rtl/iox_spi_port_chk.sv
// Property checker for iox_spi_port, attached by bind below.
module iox_spi_port_chk #(
    parameter int PORT_W = 8,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_miso,
    input logic              spi_miso_oe,
    input logic [PORT_W-1:0] port_out,
    input logic [PORT_W-1:0] port_oe,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              frame_done,
    input logic              cmp_flag
);
    localparam logic [CNT_W-1:0] CTRL_BITS = CNT_W'(8);

    AST_MISO_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_miso_oe); // R2

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |=> (spi_miso == $past(cmp_flag))); // R5

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(!spi_cs_n) && $past(!spi_cs_n, 2) && bit_cnt < CTRL_BITS)
        |-> $stable(spi_miso)); // R5

    AST_WRITE_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(port_out) || !$stable(port_oe)) |-> $past(frame_done)); // R10

    AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2))
        |-> ($stable(port_out) && $stable(port_oe))); // R10
endmodule

bind iox_spi_port iox_spi_port_chk #(.PORT_W(PORT_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .port_out(port_out), .port_oe(port_oe),
    .bit_cnt(bit_cnt), .frame_done(frame_done), .cmp_flag(cmp_flag)
);

// File: tb/sim_iox_spi_port.sv
// Self-checking bench: directed corner cases plus seeded random frames,
// compared against a behavioural model kept in bench variables.
module sim_iox_spi_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam logic [2:0] DEV = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic       miso, miso_oe;
    logic [7:0] ext = 8'h00;
    logic [7:0] pin_in, p_out, p_oe;

    int total = 0, bad = 0;
    bit finished = 0;

    logic [7:0] m_data = 0, m_dir = 0, m_ref = 0;
    logic [1:0] m_mode = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pin_in = (p_oe & p_out) | (~p_oe & ext);

    iox_spi_port u0 (
        .clk(clk), .rst_n(rst_n), .dev_addr(DEV), .spi_cs_n(cs_n),
        .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso),
        .spi_miso_oe(miso_oe), .port_in(pin_in), .port_out(p_out),
        .port_oe(p_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_pins();
        return (m_dir & m_data) | (~m_dir & ext);
    endfunction

    function automatic logic model_flag();
        logic [7:0] a, b;
        a = model_pins() & ~m_dir;
        b = m_ref & ~m_dir;
        case (m_mode)
            2'b00:   return a == b;
            2'b01:   return a != b;
            2'b10:   return a > b;
            default: return a < b;
        endcase
    endfunction

    // One framed transfer of nbits bits; checks MISO and the model after it.
    task automatic txn(input logic [7:0] c, input logic [7:0] d, input int nbits);
        logic [15:0] fr;
        logic [7:0]  fb, rb;
        logic        oe_any, exp_flag;
        logic [7:0]  exp_pins;
        bit          match;
        fr = {c, d};
        fb = '0; rb = '0; oe_any = 1'b0;
        exp_flag = model_flag();
        exp_pins = model_pins();
        match    = (c[7:5] == DEV);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b1; mosi = fr[15-i];
            repeat (HALF) @(negedge clk);
            if (i < 8) fb[7-i] = miso;
            else begin
                rb[15-i] = miso;
                if (miso_oe) oe_any = 1'b1;
            end
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
        if (nbits >= 8) chk("R5 flag bits", fb, {8{exp_flag}});
        else if (nbits >= 1) chk("R5 first flag bit", fb[7], exp_flag);
        if (nbits > 8) chk("R4 miso_oe in data byte", oe_any, match);
        if (nbits == 16 && match && !c[4]) chk("R6 R3 read byte", rb, exp_pins);
        if (nbits == 16 && match) begin
            m_mode = c[1:0];
            if (c[4]) begin
                case (c[3:2])
                    2'b00: m_data = d;
                    2'b01: m_dir  = d;
                    2'b10: m_data = m_data | d;
                    default: m_data = m_data & ~d;
                endcase
            end else m_ref = d;
        end
        chk("R11 R7 R8 R10 port_out", p_out, m_data);
        chk("R11 R7 R10 port_oe", p_oe, m_dir);
        chk("R2 deselected miso_oe", miso_oe, 1'b0);
    endtask

    function automatic logic [7:0] mk(input logic [2:0] a, input logic w,
                                      input logic [1:0] f, input logic [1:0] m);
        return {a, w, f, m};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset values
        chk("R1 port_out", p_out, 8'h00);
        chk("R1 port_oe", p_oe, 8'h00);
        chk("R2 idle miso_oe", miso_oe, 1'b0);
        // R1 R9: equal mode, zero reference, pins zero -> flag 1
        ext = 8'h00; txn(mk(DEV, 0, 2'b00, 2'b00), 8'h3C, 16);
        // R7: direction then data, R8: set and clear
        txn(mk(DEV, 1, 2'b01, 2'b00), 8'hF0, 16);
        txn(mk(DEV, 1, 2'b00, 2'b00), 8'hA5, 16);
        txn(mk(DEV, 1, 2'b10, 2'b00), 8'h0A, 16);
        txn(mk(DEV, 1, 2'b11, 2'b00), 8'h81, 16);
        // R9: each compare mode with outputs masked
        ext = 8'h5C;
        for (int m = 0; m < 4; m++) begin
            txn(mk(DEV, 0, 2'b00, m[1:0]), 8'h3B, 16);
            txn(mk(DEV, 0, 2'b00, m[1:0]), 8'h0C, 16);
            txn(mk(DEV, 0, 2'b00, m[1:0]), 8'h0D, 16);
        end
        // R4: address mismatch changes nothing
        txn(mk(DEV ^ 3'd2, 1, 2'b00, 2'b01), 8'hFF, 16);
        txn(mk(DEV ^ 3'd7, 0, 2'b00, 2'b10), 8'h77, 16);
        // R10: aborted frames change nothing
        txn(mk(DEV, 1, 2'b01, 2'b11), 8'h0F, 15);
        txn(mk(DEV, 1, 2'b00, 2'b00), 8'h00, 8);
        txn(mk(DEV, 0, 2'b00, 2'b00), 8'hEE, 3);
        txn(mk(DEV, 0, 2'b00, 2'b00), 8'h00, 16);
        // Random frames
        for (int k = 0; k < 90; k++) begin
            logic [7:0] c, d;
            int nb;
            c  = 8'($urandom);
            d  = 8'($urandom);
            if ($urandom % 5 != 0) c[7:5] = DEV;
            nb = ($urandom % 10 == 0) ? int'(1 + $urandom % 15) : 16;
            ext = 8'($urandom);
            txn(c, d, nb);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule